// File: doc/BRIEF.md
# Two-wire byte command controller

This block sits between a command interface and a bit-level controller of a master-only two-wire serial bus. Each command word carries independent start, stop, read, write and acknowledge bits and travels with a transmit byte. From them the block builds one byte transaction, in this order: an optional START condition, one data byte, the acknowledge bit, and an optional STOP condition. It hands that sequence to the bit controller one bus bit at a time.

On a write, the transmit byte is loaded into a shift register and sent most significant bit first. The block then reads the slave's acknowledge bit. On a read, eight bits are shifted in and copied to the receive register, and the acknowledge value chosen by software is driven. When the command finishes, the transfer-in-progress flag drops and the interrupt is raised. Software can poll the status outputs instead. Addresses of 7 or 10 bits are sent as ordinary write commands, one byte per command. Losing arbitration ends the byte early and raises the interrupt with a flag that records the loss.

Top module: `twb_byte_ctrl`

## Requirements
- R1: After reset, st_tip, st_rxack, st_al, irq and bit_req are 0, and rx_data is all zeros.
- R2: A cmd_wr pulse with at least one of cmd_start, cmd_stop, cmd_read or cmd_write set, while st_tip is 0, drives st_tip high on the next cycle. The block then requests the bit commands in the order START (code 1), data byte, acknowledge bit, STOP (code 2). Each phase is present only if its command bit is set. bit_req is never high while st_tip is low.
- R3: On a write, eight WRITE requests (code 3) are issued, with bit_txd carrying tx_data from bit 7 down to bit 0. A READ request (code 4) follows, and the bit_rxd value returned for it is stored in st_rxack (1 means not acknowledged).
- R4: On a read, eight READ requests are issued and the returned bits are assembled into rx_data, first bit as the MSB. A WRITE request follows, with bit_txd equal to cmd_ack.
- R5: When cmd_read and cmd_write are both set, the byte is handled as a write.
- R6: Completion of a command clears st_tip and sets irq on the same clock edge.
- R7: A cmd_wr with cmd_iack clears irq. If this falls in the same cycle as a completion, irq stays set.
- R8: While st_tip is high, the command bits and tx_data of a cmd_wr are ignored. They do not change the bit sequence or the byte that is sent.
- R9: When arb_lost is asserted while st_tip is high, the command is abandoned. On the next cycle st_tip and bit_req are 0 and irq and st_al are 1. The next accepted command clears st_al.
- R10: Once bit_req is high, it stays high with bit_cmd and bit_txd unchanged until bit_done or arb_lost is returned.
- R11: st_busy follows the bus_busy input.
- R12: A command with only cmd_stop set issues a single STOP request and completes with irq set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Generate START before the byte |
| cmd_stop | input | 1 | Generate STOP after the acknowledge |
| cmd_read | input | 1 | Read one byte |
| cmd_write | input | 1 | Write one byte |
| cmd_ack | input | 1 | Acknowledge value driven after a read |
| cmd_iack | input | 1 | Clear pending interrupt |
| tx_data | input | DW | Byte to transmit, captured with an accepted command |
| rx_data | output | DW | Last received byte |
| st_tip | output | 1 | Transfer in progress |
| st_rxack | output | 1 | Acknowledge bit sampled from the slave |
| st_busy | output | 1 | Bus busy status |
| st_al | output | 1 | Arbitration lost |
| irq | output | 1 | Interrupt pending |
| bit_req | output | 1 | Bit command request to the bit controller |
| bit_cmd | output | 3 | Bit command: 1 START, 2 STOP, 3 WRITE, 4 READ |
| bit_txd | output | 1 | Data bit for WRITE requests |
| bit_done | input | 1 | Bit controller finished the current request |
| bit_rxd | input | 1 | Bit sampled by the bit controller for READ requests |
| arb_lost | input | 1 | Bit controller lost arbitration |
| bus_busy | input | 1 | Bus busy indication from the bit controller |

## Verification
Software can clear the interrupt in the same clock cycle that a command completes and raises it. The two actions meet on the irq flag, so its priority decides which one wins. The bench drives cmd_wr with cmd_iack from inside its bit-controller model, in the very cycle it returns bit_done for the last acknowledge bit. It then expects irq to read 1 afterwards. Outside that collision, the bench confirms separately that an interrupt-clear alone returns irq to 0.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [2:0] {
        BC_NOP   = 3'd0,
        BC_START = 3'd1,
        BC_STOP  = 3'd2,
        BC_WRITE = 3'd3,
        BC_READ  = 3'd4
    } bit_cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_DATA,
        SQ_ACK,
        SQ_STOP
    } seq_state_e;

    typedef struct packed {
        logic sta;
        logic sto;
        logic rd;
        logic wr;
        logic ack;
    } cmd_t;

    function automatic logic cmd_any(input cmd_t c);
        return c.sta | c.sto | c.rd | c.wr;
    endfunction

    function automatic logic cmd_has_byte(input cmd_t c);
        return c.rd | c.wr;
    endfunction

endpackage

// File: rtl/twb_cmd_reg.sv
module twb_cmd_reg
    import twb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  cmd_t          cmd_in,
    input  logic          iack,
    input  logic [DW-1:0] tx_in,
    input  logic          done,
    input  logic          arb_lost,
    input  logic          rxack_upd,
    input  logic          rxack_val,
    output cmd_t          cmd_q,
    output logic          pending,
    output logic [DW-1:0] txr,
    output logic          irq,
    output logic          al,
    output logic          rxack
);

    logic accept;
    logic abort;

    assign accept = cmd_wr && !pending && cmd_any(cmd_in);
    assign abort  = arb_lost && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            pending <= 1'b0;
            txr     <= '0;
            irq     <= 1'b0;
            al      <= 1'b0;
            rxack   <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q   <= cmd_in;
                pending <= 1'b1;
                txr     <= tx_in;
            end else if (done || abort) begin
                cmd_q   <= '0;
                pending <= 1'b0;
            end

            if (done || abort) begin
                irq <= 1'b1;
            end else if (cmd_wr && iack) begin
                irq <= 1'b0;
            end

            if (abort) begin
                al <= 1'b1;
            end else if (accept) begin
                al <= 1'b0;
            end

            if (rxack_upd) begin
                rxack <= rxack_val;
            end
        end
    end

endmodule

// File: rtl/twb_shifter.sv
module twb_shifter #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift_en,
    input  logic          capture,
    input  logic          rxd,
    output logic          msb,
    output logic [DW-1:0] rx_data
);

    logic [DW-1:0] sh_q;

    assign msb = sh_q[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            rx_data <= '0;
        end else begin
            if (load) begin
                sh_q <= load_val;
            end else if (shift_en) begin
                sh_q <= {sh_q[DW-2:0], rxd};
            end
            if (capture) begin
                rx_data <= {sh_q[DW-2:0], rxd};
            end
        end
    end

endmodule

// File: rtl/twb_seq.sv
module twb_seq
    import twb_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned CNT_W = $clog2(DW)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pending,
    input  cmd_t     cmd_q,
    input  logic     bit_done,
    input  logic     bit_rxd,
    input  logic     arb_lost,
    input  logic     shift_msb,
    output logic     bit_req,
    output bit_cmd_e bit_cmd,
    output logic     bit_txd,
    output logic     load,
    output logic     shift_en,
    output logic     capture,
    output logic     done,
    output logic     rxack_upd,
    output logic     rxack_val
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        shift_en  = 1'b0;
        capture   = 1'b0;
        done      = 1'b0;
        rxack_upd = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (pending) begin
                    if (cmd_q.sta) begin
                        state_d = SQ_START;
                    end else if (cmd_has_byte(cmd_q)) begin
                        state_d = SQ_DATA;
                        load    = 1'b1;
                    end else begin
                        state_d = SQ_STOP;
                    end
                end
            end
            SQ_START: begin
                if (bit_done) begin
                    if (cmd_has_byte(cmd_q)) begin
                        state_d = SQ_DATA;
                        load    = 1'b1;
                    end else if (cmd_q.sto) begin
                        state_d = SQ_STOP;
                    end else begin
                        state_d = SQ_IDLE;
                        done    = 1'b1;
                    end
                end
            end
            SQ_DATA: begin
                if (bit_done) begin
                    shift_en = 1'b1;
                    if (cnt_q == LAST_BIT) begin
                        state_d = SQ_ACK;
                        capture = !cmd_q.wr;
                    end
                end
            end
            SQ_ACK: begin
                if (bit_done) begin
                    rxack_upd = cmd_q.wr;
                    if (cmd_q.sto) begin
                        state_d = SQ_STOP;
                    end else begin
                        state_d = SQ_IDLE;
                        done    = 1'b1;
                    end
                end
            end
            SQ_STOP: begin
                if (bit_done) begin
                    state_d = SQ_IDLE;
                    done    = 1'b1;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
        if (arb_lost) begin
            state_d   = SQ_IDLE;
            load      = 1'b0;
            shift_en  = 1'b0;
            capture   = 1'b0;
            done      = 1'b0;
            rxack_upd = 1'b0;
        end
    end

    assign rxack_val = bit_rxd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cnt_q <= '0;
            end else if (shift_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        bit_req = (state_q != SQ_IDLE);
        bit_txd = 1'b1;
        unique case (state_q)
            SQ_START: bit_cmd = BC_START;
            SQ_STOP:  bit_cmd = BC_STOP;
            SQ_DATA: begin
                bit_cmd = cmd_q.wr ? BC_WRITE : BC_READ;
                if (cmd_q.wr) bit_txd = shift_msb;
            end
            SQ_ACK: begin
                bit_cmd = cmd_q.wr ? BC_READ : BC_WRITE;
                if (!cmd_q.wr) bit_txd = cmd_q.ack;
            end
            default:  bit_cmd = BC_NOP;
        endcase
    end

endmodule

// File: rtl/twb_byte_ctrl.sv
module twb_byte_ctrl
    import twb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic          cmd_start,
    input  logic          cmd_stop,
    input  logic          cmd_read,
    input  logic          cmd_write,
    input  logic          cmd_ack,
    input  logic          cmd_iack,
    input  logic [DW-1:0] tx_data,
    output logic [DW-1:0] rx_data,
    output logic          st_tip,
    output logic          st_rxack,
    output logic          st_busy,
    output logic          st_al,
    output logic          irq,
    output logic          bit_req,
    output logic [2:0]    bit_cmd,
    output logic          bit_txd,
    input  logic          bit_done,
    input  logic          bit_rxd,
    input  logic          arb_lost,
    input  logic          bus_busy
);

    localparam int unsigned CNT_W = $clog2(DW);

    cmd_t          cmd_in;
    cmd_t          cmd_q;
    logic          pending;
    logic [DW-1:0] txr;
    logic          done;
    logic          rxack_upd;
    logic          rxack_val;
    logic          load;
    logic          shift_en;
    logic          capture;
    logic          shift_msb;
    bit_cmd_e      seq_cmd;

    assign cmd_in = '{sta: cmd_start, sto: cmd_stop, rd: cmd_read,
                      wr: cmd_write, ack: cmd_ack};

    twb_cmd_reg #(.DW(DW)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_in    (cmd_in),
        .iack      (cmd_iack),
        .tx_in     (tx_data),
        .done      (done),
        .arb_lost  (arb_lost),
        .rxack_upd (rxack_upd),
        .rxack_val (rxack_val),
        .cmd_q     (cmd_q),
        .pending   (pending),
        .txr       (txr),
        .irq       (irq),
        .al        (st_al),
        .rxack     (st_rxack)
    );

    twb_seq #(.DW(DW), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .cmd_q     (cmd_q),
        .bit_done  (bit_done),
        .bit_rxd   (bit_rxd),
        .arb_lost  (arb_lost),
        .shift_msb (shift_msb),
        .bit_req   (bit_req),
        .bit_cmd   (seq_cmd),
        .bit_txd   (bit_txd),
        .load      (load),
        .shift_en  (shift_en),
        .capture   (capture),
        .done      (done),
        .rxack_upd (rxack_upd),
        .rxack_val (rxack_val)
    );

    twb_shifter #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (txr),
        .shift_en (shift_en),
        .capture  (capture),
        .rxd      (bit_rxd),
        .msb      (shift_msb),
        .rx_data  (rx_data)
    );

    assign bit_cmd = seq_cmd;
    assign st_tip  = pending;
    assign st_busy = bus_busy;

endmodule

// File: rtl/twb_byte_ctrl_chk.sv
module twb_byte_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic       cmd_start,
    input logic       cmd_stop,
    input logic       cmd_read,
    input logic       cmd_write,
    input logic       cmd_iack,
    input logic       st_tip,
    input logic       st_al,
    input logic       irq,
    input logic       bit_req,
    input logic [2:0] bit_cmd,
    input logic       bit_txd,
    input logic       bit_done,
    input logic       arb_lost
);

    logic any_cmd;
    assign any_cmd = cmd_start | cmd_stop | cmd_read | cmd_write;

    AST_TIP_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && any_cmd && !st_tip |=> st_tip);  // R2

    AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !st_tip |-> !bit_req);  // R2

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(st_tip) |-> irq);  // R6

    AST_IACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && cmd_iack && !st_tip |=> !irq);  // R7

    AST_ARB_ABORT: assert property (@(posedge clk) disable iff (rst)
        arb_lost && st_tip |=> !st_tip && !bit_req && irq && st_al);  // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        bit_req && !bit_done && !arb_lost
        |=> bit_req && $stable(bit_cmd) && $stable(bit_txd));  // R10

endmodule

bind twb_byte_ctrl twb_byte_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_read  (cmd_read),
    .cmd_write (cmd_write),
    .cmd_iack  (cmd_iack),
    .st_tip    (st_tip),
    .st_al     (st_al),
    .irq       (irq),
    .bit_req   (bit_req),
    .bit_cmd   (bit_cmd),
    .bit_txd   (bit_txd),
    .bit_done  (bit_done),
    .arb_lost  (arb_lost)
);

// File: tb/twb_byte_ctrl_test.sv
`timescale 1ns/1ps
module twb_byte_ctrl_test;

    localparam int DW  = 8;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          wr_task = 1'b0, wr_resp = 1'b0, iack_t = 1'b0;
    logic          c_sta = 1'b0, c_sto = 1'b0, c_rd = 1'b0, c_wr = 1'b0, c_ack = 1'b0;
    logic [DW-1:0] tx = '0;
    logic          cmd_wr, cmd_iack;
    logic [DW-1:0] rx_data;
    logic          st_tip, st_rxack, st_busy, st_al, irq, bit_req, bit_txd;
    logic [2:0]    bit_cmd;
    logic          bit_done = 1'b0, bit_rxd = 1'b1, arb_lost = 1'b0, bus_busy = 1'b0;

    assign cmd_wr   = wr_task | wr_resp;
    assign cmd_iack = iack_t | wr_resp;

    twb_byte_ctrl #(.DW(DW)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start(c_sta), .cmd_stop(c_sto),
        .cmd_read(c_rd), .cmd_write(c_wr), .cmd_ack(c_ack), .cmd_iack(cmd_iack),
        .tx_data(tx), .rx_data(rx_data), .st_tip(st_tip), .st_rxack(st_rxack),
        .st_busy(st_busy), .st_al(st_al), .irq(irq), .bit_req(bit_req),
        .bit_cmd(bit_cmd), .bit_txd(bit_txd), .bit_done(bit_done), .bit_rxd(bit_rxd),
        .arb_lost(arb_lost), .bus_busy(bus_busy)
    );

    // Bit controller model
    logic [2:0] log_cmd [0:255];
    logic       log_txd [0:255];
    int log_n = 0, rd_cnt = 0, wcnt = 0;
    int arb_at = -1, iack_at = -1, rd_base = 0;
    logic [8:0] rx_stream = '1;
    int tests = 0, fails = 0, cycles = 0;

    always @(negedge clk) begin
        if (bit_done || arb_lost || wr_resp) begin
            bit_done = 1'b0; arb_lost = 1'b0; wr_resp = 1'b0; wcnt = 0;
        end else if (bit_req) begin
            if (wcnt == LAT) begin
                log_cmd[log_n] = bit_cmd;
                log_txd[log_n] = bit_txd;
                if (bit_cmd == 3'd4) begin
                    automatic int k = rd_cnt - rd_base;
                    bit_rxd = (k <= 8) ? rx_stream[8-k] : 1'b1;
                    rd_cnt++;
                end else begin
                    bit_rxd = 1'b1;
                end
                if (log_n == arb_at) arb_lost = 1'b1;
                else begin
                    bit_done = 1'b1;
                    if (log_n == iack_at) wr_resp = 1'b1;
                end
                log_n++;
            end else wcnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit sta, sto, rd, wr, ack, iack, input logic [DW-1:0] d);
        @(negedge clk);
        c_sta = sta; c_sto = sto; c_rd = rd; c_wr = wr; c_ack = ack; iack_t = iack; tx = d;
        wr_task = 1'b1;
        @(negedge clk);
        wr_task = 1'b0; c_sta = 0; c_sto = 0; c_rd = 0; c_wr = 0; c_ack = 0; iack_t = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (st_tip && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) chk(0, "timeout", 1, 0);
    endtask

    task automatic chk_byte(input int base, input logic [DW-1:0] d, input string req);
        for (int i = 0; i < DW; i++) begin
            chk(log_cmd[base+i] == 3'd3 && log_txd[base+i] == d[DW-1-i], req,
                {log_cmd[base+i], log_txd[base+i]}, {3'd3, d[DW-1-i]});
        end
    endtask

    task automatic t_reset();
        chk(!st_tip && !st_rxack && !st_al && !irq && !bit_req, "R1 flags", 
            {st_tip, st_rxack, st_al, irq, bit_req}, 0);
        chk(rx_data == '0, "R1 rx_data", rx_data, 0);
    endtask

    task automatic t_write_start();
        int b = log_n;
        rx_stream = 9'b0_0000_0000; rd_base = rd_cnt;
        issue(1, 0, 0, 1, 0, 0, 8'hA5);
        chk(st_tip, "R2 tip after accept", st_tip, 1);
        wait_idle();
        chk(log_n - b == 10, "R2 count", log_n - b, 10);
        chk(log_cmd[b] == 3'd1, "R2 start first", log_cmd[b], 1);
        chk_byte(b + 1, 8'hA5, "R3 write bits");
        chk(log_cmd[b+9] == 3'd4, "R3 ack read", log_cmd[b+9], 4);
        chk(st_rxack == 1'b0, "R3 rxack", st_rxack, 0);
        chk(irq && !st_tip, "R6 irq at end", {irq, st_tip}, 2'b10);
    endtask

    task automatic t_iack();
        issue(0, 0, 0, 0, 0, 1, 8'h00);
        chk(!irq, "R7 iack clears", irq, 0);
        chk(!st_tip, "R7 iack alone starts nothing", st_tip, 0);
    endtask

    task automatic t_read_stop();
        int b = log_n;
        rx_stream = {8'h3C, 1'b0}; rd_base = rd_cnt;
        issue(0, 1, 1, 0, 1, 0, 8'hFF);
        wait_idle();
        chk(log_n - b == 10, "R4 count", log_n - b, 10);
        for (int i = 0; i < 8; i++)
            chk(log_cmd[b+i] == 3'd4, "R4 read cmd", log_cmd[b+i], 4);
        chk(log_cmd[b+8] == 3'd3 && log_txd[b+8] == 1'b1, "R4 ack value",
            {log_cmd[b+8], log_txd[b+8]}, {3'd3, 1'b1});
        chk(log_cmd[b+9] == 3'd2, "R2 stop last", log_cmd[b+9], 2);
        chk(rx_data == 8'h3C, "R4 rx_data", rx_data, 8'h3C);
    endtask

    task automatic t_nack();
        int b = log_n;
        rx_stream = 9'b1_0000_0000; rd_base = rd_cnt;
        issue(0, 0, 0, 1, 0, 1, 8'h5A);
        wait_idle();
        chk(log_n - b == 9, "R2 no start", log_n - b, 9);
        chk_byte(b, 8'h5A, "R3 write bits 5A");
        chk(st_rxack == 1'b1, "R3 nack", st_rxack, 1);
    endtask

    task automatic t_busy_ignore();
        int b = log_n;
        rx_stream = 9'b0; rd_base = rd_cnt;
        issue(1, 0, 0, 1, 0, 0, 8'hF0);
        repeat (3) @(negedge clk);
        issue(0, 1, 1, 0, 1, 0, 8'h0F);
        wait_idle();
        chk(log_n - b == 10, "R8 count", log_n - b, 10);
        chk_byte(b + 1, 8'hF0, "R8 byte kept");
        chk(log_cmd[b+9] == 3'd4, "R8 no stop added", log_cmd[b+9], 4);
    endtask

    task automatic t_arb();
        int b = log_n;
        issue(0, 0, 0, 0, 0, 1, 8'h00);
        rx_stream = 9'b0; rd_base = rd_cnt; arb_at = b + 3;
        issue(1, 1, 0, 1, 0, 0, 8'hC3);
        wait_idle();
        arb_at = -1;
        chk(st_al && irq, "R9 al and irq", {st_al, irq}, 2'b11);
        repeat (6) @(negedge clk);
        chk(log_n - b == 4 && !bit_req, "R9 aborted", log_n - b, 4);
        b = log_n;
        issue(0, 1, 0, 0, 0, 1, 8'h00);
        wait_idle();
        chk(!st_al, "R9 al cleared", st_al, 0);
        chk(log_n - b == 1 && log_cmd[b] == 3'd2, "R12 stop only", log_cmd[b], 2);
        chk(irq, "R12 irq", irq, 1);
    endtask

    task automatic t_same_cycle();
        int b = log_n;
        issue(0, 0, 0, 0, 0, 1, 8'h00);
        rx_stream = 9'b0; rd_base = rd_cnt; iack_at = b + 8;
        issue(0, 0, 0, 1, 0, 0, 8'h11);
        wait_idle();
        iack_at = -1;
        @(negedge clk);
        chk(irq, "R7 set beats clear", irq, 1);
    endtask

    task automatic t_both();
        int b = log_n;
        rx_stream = 9'b0; rd_base = rd_cnt;
        issue(0, 0, 1, 1, 0, 1, 8'h81);
        wait_idle();
        chk(log_n - b == 9, "R5 count", log_n - b, 9);
        chk_byte(b, 8'h81, "R5 write wins");
        chk(log_cmd[b+8] == 3'd4, "R5 ack read", log_cmd[b+8], 4);
    endtask

    task automatic t_busy();
        @(negedge clk); bus_busy = 1'b1;
        #1 chk(st_busy, "R11 busy high", st_busy, 1);
        @(negedge clk); bus_busy = 1'b0;
        #1 chk(!st_busy, "R11 busy low", st_busy, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_start();
        t_iack();
        t_read_stop();
        t_nack();
        t_busy_ignore();
        t_arb();
        t_same_cycle();
        t_both();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule